// File: doc/BRIEF.md
# Parallel ADC Sampling Controller

This block sits in the fast system clock domain and runs an external 12-bit parallel-output successive-approximation converter. A conversion starts when the block drives the active-low convert strobe low and then high again. The rising edge puts the converter into hold. The converter pulls its active-low busy line low while it works and releases it when the result is ready. The block then runs one chip-select/read cycle on the parallel bus, captures the word, and hands it to the core on a valid/ready port. Each delivered word also raises a one-cycle interrupt pulse.

Two sources can start a conversion. One is a free-running sample timer whose period is set in system clocks and is held at or above the converter's full cycle time. The other is a one-cycle software start pulse. Every nanosecond limit of the converter bus is turned into a cycle count from the system clock frequency, always rounded up. When the core asks for sleep, the converter is put into its low-power mode. On wake, the block first runs one throw-away conversion, because the first result after power-down cannot be trusted. A timer tick that arrives while an undelivered word is still waiting is dropped and reported as an overrun.

Top module: `adc_acq_ctrl`

## Requirements
- R1: While reset is high and directly after it, convert, chip-select and read are high, the power mode output is high (awake), and out_valid, irq and overrun are low.
- R2: The convert strobe stays low for at least ceil(50 ns × SYS_CLK_MHZ / 1000) cycles (5 at 100 MHz) before its rising edge.
- R3: After the convert rising edge, busy is not used as a completion indication for ceil(130 ns) cycles plus the synchronizer depth. A read never begins while busy is low, or before busy has gone low and come back high for that conversion.
- R4: Chip-select is low no later than the cycle in which read falls, and stays low until read rises.
- R5: Read stays low for max(ceil(75 ns), ceil(70 ns)) cycles (8 at 100 MHz). The data word is captured on the clock edge that raises read, with bit 0 of adc_data appearing as bit 0 of out_data.
- R6: After read rises, the bus stays idle for ceil(50 ns) cycles. out_valid rises exactly ceil(50 ns) + 1 cycles after read rises (6 at 100 MHz).
- R7: With the timer enabled, convert rising edges are spaced exactly max(period_cfg, ceil(15000 ns)) cycles apart (a floor of 1500 at 100 MHz).
- R8: A one-cycle sw_start pulse starts a conversion. A start request that arrives while a conversion is in progress is held and served once the current one finishes.
- R9: out_data and out_valid hold steady until out_ready is seen high. irq pulses for exactly one cycle for each word delivered.
- R10: A timer tick that arrives while out_valid is high starts no conversion, and overrun pulses for one cycle.
- R11: While sleep_req is high and the block is idle, adc_pd_n is low, and start requests are dropped without any convert pulse.
- R12: When sleep_req falls, adc_pd_n goes high and exactly one conversion runs whose result is thrown away (no out_valid, no irq). The next requested conversion delivers its word normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_en | input | 1 | Enables the periodic sample timer |
| period_cfg | input | PERIOD_W | Sample period in system clocks, held at or above the minimum |
| sw_start | input | 1 | One-cycle software conversion request |
| sleep_req | input | 1 | Requests the converter's low-power mode |
| adc_busy_n | input | 1 | Converter busy line, low during conversion (asynchronous) |
| adc_data | input | DATA_W | Converter parallel data bus |
| adc_convst_n | output | 1 | Convert strobe; rising edge starts conversion |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_pd_n | output | 1 | Converter power mode, low selects power save |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_data | output | DATA_W | Captured conversion word |
| out_valid | output | 1 | out_data holds an undelivered word |
| irq | output | 1 | One-cycle pulse per delivered word |
| overrun | output | 1 | One-cycle pulse when a timer tick is dropped |

## Verification
The main data path is driven with all-zeros and all-ones words, the two alternating-bit words, and a walking one across all twelve bits. This shows that every bit lands in the right position and is sampled only after the model's access time. If the bus is read too early, the model returns the inverted word, so an early read shows up as a wrong value rather than going unseen. The model's busy line falls late, just inside the allowed window, and the bus holds the inverted word until the conversion really ends. Because of that, a controller that skips the busy window or reads during busy gets caught. The timer is run both below the minimum period and above it, to separate the clamp from a plain reload. Tick-during-valid, back-to-back software requests, and a sleep/wake cycle cover the dropped-tick, held-request and discard paths.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLEEP,
    ST_CONV,
    ST_HOLD,
    ST_DONE,
    ST_CS,
    ST_RD,
    ST_REL
  } seq_state_t;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_sample_timer.sv
module adc_sample_timer #(
  parameter int PERIOD_W = 16,
  parameter int MIN_CYC  = 1500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period_cfg,
  output logic                tick
);
  localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_CYC);

  logic [PERIOD_W-1:0] eff;
  logic [PERIOD_W-1:0] cnt;

  assign eff = (period_cfg < MIN_P) ? MIN_P : period_cfg;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= eff - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // independent spacing monitor for the clamp
  logic [PERIOD_W-1:0] gap;
  logic                seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= {{(PERIOD_W-1){1'b0}}, 1'b1};
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  a_r7_min_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && seen) |-> (gap >= MIN_P));

endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_acq_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CONV_LOW_CYC = 5,
  parameter int HOLD_CYC     = 15,
  parameter int RD_CYC       = 8,
  parameter int REL_CYC      = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              sleep_req,
  input  logic              busy_n_in,
  input  logic [DATA_W-1:0] bus_data,
  output logic              convst_n,
  output logic              cs_n,
  output logic              rd_n,
  output logic              pd_n,
  output logic              word_stb,
  output logic [DATA_W-1:0] word_data
);
  localparam int MAXC  = imax(imax(CONV_LOW_CYC, HOLD_CYC), imax(RD_CYC, REL_CYC));
  localparam int CNT_W = $clog2(MAXC + 1) + 1;
  localparam logic [CNT_W-1:0] CONV_END = CNT_W'(CONV_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_END   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] REL_END  = CNT_W'(REL_CYC - 1);

  // busy synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) sync_q[g] <= rst ? 1'b1 : busy_n_in;
      end else begin : g_next
        always_ff @(posedge clk) sync_q[g] <= rst ? 1'b1 : sync_q[g-1];
      end
    end
  endgenerate
  logic busy_s;
  assign busy_s = sync_q[SYNC_STAGES-1];

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             discard;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      convst_n  <= 1'b1;
      cs_n      <= 1'b1;
      rd_n      <= 1'b1;
      pd_n      <= 1'b1;
      pend      <= 1'b0;
      discard   <= 1'b0;
      word_stb  <= 1'b0;
      word_data <= '0;
    end else begin
      word_stb <= 1'b0;
      if (start_req && state != ST_IDLE && state != ST_SLEEP) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (sleep_req) begin
            state <= ST_SLEEP;
            pd_n  <= 1'b0;
            pend  <= 1'b0;
          end else if (pend || start_req) begin
            state    <= ST_CONV;
            convst_n <= 1'b0;
            cnt      <= '0;
            pend     <= 1'b0;
          end
        end
        ST_SLEEP: begin
          if (!sleep_req) begin
            pd_n     <= 1'b1;
            discard  <= 1'b1;
            state    <= ST_CONV;
            convst_n <= 1'b0;
            cnt      <= '0;
          end
        end
        ST_CONV: begin
          if (cnt == CONV_END) begin
            convst_n <= 1'b1;
            cnt      <= '0;
            state    <= ST_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == HOLD_END) state <= ST_DONE;
          else cnt <= cnt + 1'b1;
        end
        ST_DONE: begin
          if (busy_s) begin
            cs_n  <= 1'b0;
            state <= ST_CS;
          end
        end
        ST_CS: begin
          rd_n  <= 1'b0;
          cnt   <= '0;
          state <= ST_RD;
        end
        ST_RD: begin
          if (cnt == RD_END) begin
            rd_n      <= 1'b1;
            cs_n      <= 1'b1;
            word_data <= bus_data;
            cnt       <= '0;
            state     <= ST_REL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REL: begin
          if (cnt == REL_END) begin
            state <= ST_IDLE;
            if (discard) discard  <= 1'b0;
            else         word_stb <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // pulse-width monitors, separate from the sequencer counter
  logic [CNT_W-1:0] cv_lo;
  logic [CNT_W-1:0] rd_lo;
  always_ff @(posedge clk) begin
    if (rst) begin
      cv_lo <= '0;
      rd_lo <= '0;
    end else begin
      cv_lo <= convst_n ? '0 : ((cv_lo == '1) ? cv_lo : cv_lo + 1'b1);
      rd_lo <= rd_n     ? '0 : ((rd_lo == '1) ? rd_lo : rd_lo + 1'b1);
    end
  end

  a_r2_convst_width: assert property (@(posedge clk) disable iff (rst)
    $rose(convst_n) |-> (cv_lo >= CNT_W'(CONV_LOW_CYC)));

  a_r3_no_read_in_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> busy_s);

  a_r4_cs_covers_rd: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n);

  a_r5_rd_width: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> (rd_lo >= CNT_W'(RD_CYC)));

  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    !pd_n |-> (convst_n && cs_n && rd_n));

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic [DATA_W-1:0] word_data,
  input  logic              out_ready,
  input  logic              tick_lost,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              irq,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      irq       <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      irq     <= word_stb;
      overrun <= tick_lost;
      if (word_stb) begin
        out_valid <= 1'b1;
        out_data  <= word_data;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !word_stb) |=> (out_valid && $stable(out_data)));

  a_r9_irq_with_word: assert property (@(posedge clk) disable iff (rst)
    irq |-> out_valid);

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int SYS_CLK_MHZ = 100,
  parameter int DATA_W      = 12,
  parameter int PERIOD_W    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_LOW_NS = 50,
  parameter int BUSY_WIN_NS = 130,
  parameter int RD_LOW_NS   = 75,
  parameter int ACCESS_NS   = 70,
  parameter int RELQ_NS     = 50,
  parameter int CYCLE_NS    = 15000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                timer_en,
  input  logic [PERIOD_W-1:0] period_cfg,
  input  logic                sw_start,
  input  logic                sleep_req,
  input  logic                adc_busy_n,
  input  logic [DATA_W-1:0]   adc_data,
  output logic                adc_convst_n,
  output logic                adc_cs_n,
  output logic                adc_rd_n,
  output logic                adc_pd_n,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_valid,
  output logic                irq,
  output logic                overrun
);
  localparam int CONV_LOW_CYC = ns2cyc(CONV_LOW_NS, SYS_CLK_MHZ);
  localparam int HOLD_CYC     = ns2cyc(BUSY_WIN_NS, SYS_CLK_MHZ) + SYNC_STAGES;
  localparam int RD_CYC       = imax(ns2cyc(RD_LOW_NS, SYS_CLK_MHZ), ns2cyc(ACCESS_NS, SYS_CLK_MHZ));
  localparam int REL_CYC      = ns2cyc(RELQ_NS, SYS_CLK_MHZ);
  localparam int MIN_CYC      = ns2cyc(CYCLE_NS, SYS_CLK_MHZ);

  logic              tick;
  logic              start_req;
  logic              tick_lost;
  logic              word_stb;
  logic [DATA_W-1:0] word_data;

  adc_sample_timer #(
    .PERIOD_W (PERIOD_W),
    .MIN_CYC  (MIN_CYC)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .en         (timer_en),
    .period_cfg (period_cfg),
    .tick       (tick)
  );

  assign tick_lost = tick & out_valid;
  assign start_req = (tick & ~out_valid) | sw_start;

  adc_bus_seq #(
    .DATA_W       (DATA_W),
    .CONV_LOW_CYC (CONV_LOW_CYC),
    .HOLD_CYC     (HOLD_CYC),
    .RD_CYC       (RD_CYC),
    .REL_CYC      (REL_CYC),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .sleep_req (sleep_req),
    .busy_n_in (adc_busy_n),
    .bus_data  (adc_data),
    .convst_n  (adc_convst_n),
    .cs_n      (adc_cs_n),
    .rd_n      (adc_rd_n),
    .pd_n      (adc_pd_n),
    .word_stb  (word_stb),
    .word_data (word_data)
  );

  adc_out_stage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .word_stb  (word_stb),
    .word_data (word_data),
    .out_ready (out_ready),
    .tick_lost (tick_lost),
    .out_data  (out_data),
    .out_valid (out_valid),
    .irq       (irq),
    .overrun   (overrun)
  );

  a_r10_lost_tick_no_start: assert property (@(posedge clk) disable iff (rst)
    (tick_lost && !sw_start) |=> adc_convst_n);

endmodule

// File: tb/adc_acq_ctrl_tb.sv
module adc_acq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 12;
  localparam int CONV_LOW   = 5;
  localparam int RD_MIN     = 8;
  localparam int REL        = 5;
  localparam int MIN_PER    = 1500;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          timer_en = 1'b0;
  logic [15:0]   period_cfg = '0;
  logic          sw_start = 1'b0;
  logic          sleep_req = 1'b0;
  logic          adc_busy_n = 1'b1;
  logic [DW-1:0] adc_data = '0;
  logic          adc_convst_n, adc_cs_n, adc_rd_n, adc_pd_n;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_valid, irq, overrun;

  adc_acq_ctrl u_dut (
    .clk(clk), .rst(rst), .timer_en(timer_en), .period_cfg(period_cfg),
    .sw_start(sw_start), .sleep_req(sleep_req), .adc_busy_n(adc_busy_n),
    .adc_data(adc_data), .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n),
    .adc_rd_n(adc_rd_n), .adc_pd_n(adc_pd_n), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .irq(irq), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model and bus monitor
  int cyc = 0, cv_lo = 0, rd_lo = 0, busy_ctr = 0;
  int cv_rises = 0, last_rise = 0, last_int = 0, rd_rise = 0;
  int irq_cnt = 0, ov_cnt = 0;
  bit cv_prev = 1, rd_prev = 1, v_prev = 0, done = 0;
  logic [DW-1:0] latched = '0;
  logic [DW-1:0] next_val = '0;

  always @(negedge clk) begin
    cyc++;
    if (!adc_convst_n) begin
      cv_lo++;
      if (busy_ctr > 0) begin busy_ctr--; if (busy_ctr == 0) done = 1; end
    end else if (!cv_prev && !rst) begin
      chk(cv_lo >= CONV_LOW, "R2 convst low width", cv_lo, CONV_LOW);
      if (cv_rises > 0) last_int = cyc - last_rise;
      last_rise = cyc;
      cv_rises++;
      latched  = next_val;
      busy_ctr = 52;
      done     = 0;
      cv_lo    = 0;
    end else begin
      cv_lo = 0;
      if (busy_ctr > 0) begin busy_ctr--; if (busy_ctr == 0) done = 1; end
    end
    cv_prev = adc_convst_n;
    adc_busy_n = !(busy_ctr > 0 && busy_ctr <= 40);

    if (!adc_rd_n) begin
      if (rd_prev) begin
        chk(done && adc_busy_n, "R3 read only after conversion end", int'(done), 1);
        chk(!adc_cs_n, "R4 cs low at read fall", int'(adc_cs_n), 0);
      end
      rd_lo++;
    end else begin
      if (!rd_prev) begin
        chk(rd_lo >= RD_MIN, "R5 read low width", rd_lo, RD_MIN);
        rd_rise = cyc;
      end
      rd_lo = 0;
    end
    rd_prev = adc_rd_n;
    adc_data = (!adc_rd_n && rd_lo >= RD_MIN && done) ? latched : ~latched;

    if (out_valid && !v_prev && !rst)
      chk(cyc - rd_rise == REL + 1, "R6 bus release before delivery", cyc - rd_rise, REL + 1);
    v_prev = out_valid;
    if (irq) irq_cnt++;
    if (overrun) ov_cnt++;
  end

  task automatic pulse_start();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic get_word(input logic [DW-1:0] v);
    int i0;
    next_val = v;
    i0 = irq_cnt;
    pulse_start();
    for (int k = 0; k < 300 && !out_valid; k++) @(negedge clk);
    chk(out_valid && out_data == v, "R5 captured word", int'(out_data), int'(v));
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == v, "R9 held without ready", int'(out_valid), 1);
    chk(irq_cnt == i0 + 1, "R9 one irq per word", irq_cnt - i0, 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R9 valid drops after ready", int'(out_valid), 0);
  endtask

  task automatic wait_rises(input int n);
    int b;
    b = cv_rises;
    for (int k = 0; k < 20000 && cv_rises < b + n; k++) @(negedge clk);
  endtask

  initial begin
    int c0, i0, o0;
    repeat (5) @(negedge clk);
    chk(adc_convst_n && adc_cs_n && adc_rd_n, "R1 bus idle in reset", 0, 1);
    chk(adc_pd_n && !out_valid && !irq && !overrun, "R1 flags in reset", 0, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(adc_convst_n && adc_pd_n && !out_valid, "R1 idle after reset", 0, 1);

    // data pattern sweep
    get_word(12'h000);
    get_word(12'hFFF);
    get_word(12'h555);
    get_word(12'hAAA);
    for (int b = 0; b < DW; b++) get_word(DW'(1) << b);

    // held request during a conversion (R8)
    c0 = cv_rises; i0 = irq_cnt;
    next_val = 12'h123;
    out_ready = 1'b1;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (250) @(negedge clk);
    chk(cv_rises == c0 + 2, "R8 held start served", cv_rises - c0, 2);
    chk(irq_cnt == i0 + 2, "R8 two words delivered", irq_cnt - i0, 2);

    // timer clamp and plain period (R7)
    period_cfg = 16'd100;
    timer_en = 1'b1;
    wait_rises(3);
    chk(last_int == MIN_PER, "R7 clamped period", last_int, MIN_PER);
    period_cfg = 16'd1800;
    wait_rises(3);
    chk(last_int == 1800, "R7 programmed period", last_int, 1800);
    timer_en = 1'b0;
    repeat (200) @(negedge clk);

    // overrun (R10)
    out_ready = 1'b0;
    period_cfg = '0;
    next_val = 12'h3C3;
    timer_en = 1'b1;
    for (int k = 0; k < 3000 && !out_valid; k++) @(negedge clk);
    c0 = cv_rises; o0 = ov_cnt;
    repeat (1600) @(negedge clk);
    chk(ov_cnt == o0 + 1, "R10 overrun pulse", ov_cnt - o0, 1);
    chk(cv_rises == c0, "R10 tick dropped", cv_rises - c0, 0);
    chk(out_valid && out_data == 12'h3C3, "R9 word kept across overrun", int'(out_data), 'h3C3);
    timer_en = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    repeat (50) @(negedge clk);

    // sleep and wake (R11, R12)
    sleep_req = 1'b1;
    repeat (5) @(negedge clk);
    chk(!adc_pd_n, "R11 power save asserted", int'(adc_pd_n), 0);
    c0 = cv_rises; i0 = irq_cnt;
    pulse_start();
    repeat (100) @(negedge clk);
    chk(cv_rises == c0, "R11 start dropped in sleep", cv_rises - c0, 0);
    chk(!adc_pd_n, "R11 still asleep", int'(adc_pd_n), 0);
    next_val = 12'h0F0;
    sleep_req = 1'b0;
    repeat (200) @(negedge clk);
    chk(adc_pd_n, "R12 awake", int'(adc_pd_n), 1);
    chk(cv_rises == c0 + 1, "R12 one discard conversion", cv_rises - c0, 1);
    chk(irq_cnt == i0 && !out_valid, "R12 discard not delivered", irq_cnt - i0, 0);
    get_word(12'h70F);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule